// File: doc/BRIEF.md
# Power-on reset delay generator

This block generates the system reset for a processor. Two things force reset: a supply-good flag that is already synchronized and comes from an external voltage comparator, and an active-low manual reset request. Reset goes active on the next clock edge after either one appears. It stays active while either one is present.

Reset is released only after a hold-off interval. The interval is counted in timebase ticks and starts once both conditions are clear. The ticks are single-cycle clock enables from a free-running divider, so the hold-off period is the tick spacing multiplied by `HOLD_TICKS`. If a condition returns before release, or after release, reset goes active again and the count starts over from zero.

The manual input is treated as asynchronous. It passes through a synchronizer of `SYNC_STAGES` flops and then a qualifier, so a low pulse shorter than `MIN_PULSE` clock cycles is dropped. Both output polarities come from one register, so the two outputs can never disagree.

Top module: `por_hold_gen`

## Requirements
- R1: While `arst_n` is low, and directly after it rises, `rst_out` is 1 and `rst_out_n` is 0.
- R2: `rst_out` is the logical complement of `rst_out_n` on every cycle.
- R3: When `supply_ok` is 0 at a clock edge, reset is active after that edge. Reset stays active for as long as `supply_ok` stays 0, whatever arrives on `tick`.
- R4: A manual request is recognized once `man_rst_n` has been 0 at `MIN_PULSE` consecutive clock edges. Reset becomes active at clock edge number `SYNC_STAGES + MIN_PULSE + 1`, counting the first edge at which the input is 0 as edge 1. Reset is not active at the edge before that one.
- R5: A low pulse on `man_rst_n` that is seen at fewer than `MIN_PULSE` consecutive edges leaves the reset outputs unchanged.
- R6: With both conditions clear, reset is released at the edge that carries the `HOLD_TICKS`-th tick counted after the conditions cleared. It is still active after `HOLD_TICKS - 1` such ticks.
- R7: If either condition reappears during the hold-off, even for one cycle, the tick count restarts from zero. A full `HOLD_TICKS` ticks are then needed after it clears again.
- R8: After `man_rst_n` returns high, ticks begin to count from the clock edge `SYNC_STAGES + 2` onward (the first edge at which the input is high is edge 1). Reset is then released after `HOLD_TICKS` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous power-up reset, active low; forces reset active |
| tick | input | 1 | Single-cycle timebase enable from the oscillator divider |
| supply_ok | input | 1 | Synchronized supply-good flag; 0 means the supply is below threshold |
| man_rst_n | input | 1 | Asynchronous manual reset request, active low |
| rst_out_n | output | 1 | System reset, active low |
| rst_out | output | 1 | System reset, active high |

## Verification
Some properties are checked on every cycle:
- The two outputs are complementary.
- A low supply flag or a qualified manual request leads to an asserted reset with the tick counter at zero on the next edge.
- The counter stays below its terminal value.
- A release happens only on an edge that carried a tick while both conditions were clear.

Other behaviour can be shown only by the bench's timed scenarios:
- The exact release edge after the `HOLD_TICKS`-th tick.
- The restart after a one-cycle supply dip.
- The latency from a manual request to reset.
- Dropping a pulse one cycle shorter than the qualifier width.
- The delayed start of the hold-off after a manual release.

// File: rtl/por_pkg.sv
package por_pkg;

    typedef enum logic {
        HOLD_FREE = 1'b0,
        HOLD_HELD = 1'b1
    } hold_state_e;

endpackage

// File: rtl/por_mr_sync.sv
module por_mr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic din,
    output logic dout
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            s_q <= '{chain: '1};
        end else begin
            s_q <= s_d;
        end
    end

    assign dout = s_q.chain[STAGES-1];

endmodule

// File: rtl/por_mr_filter.sv
module por_mr_filter #(
    parameter int MIN_PULSE = 4
) (
    input  logic clk,
    input  logic arst_n,
    input  logic sync_n,
    output logic man_act
);

    localparam int            PW_W = $clog2(MIN_PULSE + 1);
    localparam logic [PW_W-1:0] FULL = PW_W'(MIN_PULSE);

    typedef struct packed {
        logic [PW_W-1:0] lo_cnt;
    } filt_t;

    filt_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (sync_n) begin
            f_d.lo_cnt = '0;
        end else if (f_q.lo_cnt != FULL) begin
            f_d.lo_cnt = f_q.lo_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            f_q <= '{lo_cnt: '0};
        end else begin
            f_q <= f_d;
        end
    end

    assign man_act = (f_q.lo_cnt == FULL);

endmodule

// File: rtl/por_hold_ctrl.sv
module por_hold_ctrl
    import por_pkg::*;
#(
    parameter int HOLD_TICKS = 200,
    parameter int CNT_W      = $clog2(HOLD_TICKS + 1)
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             tick,
    input  logic             hold_req,
    output logic             rst_on,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

    typedef struct packed {
        hold_state_e      st;
        logic [CNT_W-1:0] cnt;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (hold_req) begin
            h_d.st  = HOLD_HELD;
            h_d.cnt = '0;
        end else if (h_q.st == HOLD_HELD && tick) begin
            if (h_q.cnt == LAST) begin
                h_d.st  = HOLD_FREE;
                h_d.cnt = '0;
            end else begin
                h_d.cnt = h_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            h_q <= '{st: HOLD_HELD, cnt: '0};
        end else begin
            h_q <= h_d;
        end
    end

    assign rst_on = (h_q.st == HOLD_HELD);
    assign cnt    = h_q.cnt;

endmodule

// File: rtl/por_hold_gen.sv
module por_hold_gen #(
    parameter int HOLD_TICKS  = 200,
    parameter int MIN_PULSE   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic tick,
    input  logic supply_ok,
    input  logic man_rst_n,
    output logic rst_out_n,
    output logic rst_out
);

    localparam int CNT_W = $clog2(HOLD_TICKS + 1);

    logic             man_sync_n;
    logic             man_act;
    logic             hold_req;
    logic             rst_on;
    logic [CNT_W-1:0] hold_cnt;

    por_mr_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .arst_n(arst_n),
        .din   (man_rst_n),
        .dout  (man_sync_n)
    );

    por_mr_filter #(
        .MIN_PULSE(MIN_PULSE)
    ) u_filt (
        .clk    (clk),
        .arst_n (arst_n),
        .sync_n (man_sync_n),
        .man_act(man_act)
    );

    assign hold_req = !supply_ok || man_act;

    por_hold_ctrl #(
        .HOLD_TICKS(HOLD_TICKS),
        .CNT_W     (CNT_W)
    ) u_hold (
        .clk     (clk),
        .arst_n  (arst_n),
        .tick    (tick),
        .hold_req(hold_req),
        .rst_on  (rst_on),
        .cnt     (hold_cnt)
    );

    assign rst_out   = rst_on;
    assign rst_out_n = ~rst_on;

endmodule

// File: rtl/por_hold_gen_chk.sv
module por_hold_gen_chk #(
    parameter int HOLD_TICKS = 200,
    parameter int CNT_W      = 8
) (
    input logic             clk,
    input logic             arst_n,
    input logic             tick,
    input logic             supply_ok,
    input logic             man_act,
    input logic [CNT_W-1:0] hold_cnt,
    input logic             rst_out_n,
    input logic             rst_out
);

    // R1: outputs active while the power-up reset is applied
    a_r1_reset_active: assert property (@(posedge clk)
        !arst_n |-> (rst_out && !rst_out_n));

    // R2: the two polarities never disagree
    a_r2_complement: assert property (@(posedge clk) disable iff (!arst_n)
        rst_out == !rst_out_n);

    // R3: a low supply flag asserts reset and clears the count
    a_r3_supply_low: assert property (@(posedge clk) disable iff (!arst_n)
        !supply_ok |=> (rst_out && hold_cnt == '0));

    // R4 / R7: a qualified manual request asserts reset and clears the count
    a_r4_manual_holds: assert property (@(posedge clk) disable iff (!arst_n)
        man_act |=> (rst_out && hold_cnt == '0));

    // R6: release only on a tick with both conditions clear
    a_r6_release_on_tick: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(rst_out) |-> ($past(tick) && $past(supply_ok) && !$past(man_act)));

    // R6: the counter never reaches the terminal count
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!arst_n)
        hold_cnt < CNT_W'(HOLD_TICKS));

endmodule

bind por_hold_gen por_hold_gen_chk #(
    .HOLD_TICKS(HOLD_TICKS),
    .CNT_W     (CNT_W)
) u_chk (
    .clk      (clk),
    .arst_n   (arst_n),
    .tick     (tick),
    .supply_ok(supply_ok),
    .man_act  (man_act),
    .hold_cnt (hold_cnt),
    .rst_out_n(rst_out_n),
    .rst_out  (rst_out)
);

// File: tb/sim_por_hold_gen.sv
module sim_por_hold_gen;

    localparam int HOLD = 8;
    localparam int MINP = 3;

    logic clk = 1'b0;
    logic arst_n;
    logic tick;
    logic supply_ok;
    logic man_rst_n;
    logic rst_out_n;
    logic rst_out;

    typedef struct {
        string tag;
        logic  on;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;

    always #2.5ns clk = ~clk;

    por_hold_gen #(
        .HOLD_TICKS (HOLD),
        .MIN_PULSE  (MINP),
        .SYNC_STAGES(2)
    ) u0 (
        .clk      (clk),
        .arst_n   (arst_n),
        .tick     (tick),
        .supply_ok(supply_ok),
        .man_rst_n(man_rst_n),
        .rst_out_n(rst_out_n),
        .rst_out  (rst_out)
    );

    // monitor: compares outputs after each edge that has a pending expectation
    always @(posedge clk) begin
        #1ns;
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            n_checks++;
            if (rst_out !== it.on) begin
                n_fails++;
                $display("FAIL %s: rst_out=%b expected %b", it.tag, rst_out, it.on);
            end
            n_checks++;
            if (rst_out_n !== ~it.on) begin
                n_fails++;
                $display("FAIL R2 (%s): rst_out_n=%b expected %b", it.tag, rst_out_n, ~it.on);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_on(input string tag, input logic on);
        exp_q.push_back('{tag: tag, on: on});
        @(negedge clk);
    endtask

    task automatic tick_once();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick_once();
    endtask

    initial begin
        arst_n    = 1'b1;
        supply_ok = 1'b0;
        man_rst_n = 1'b1;
        tick      = 1'b0;
        #1ns arst_n = 1'b0;
        step(2);
        expect_on("R1 during reset", 1'b1);
        arst_n = 1'b1;
        expect_on("R1 after reset", 1'b1);

        // R6: release exactly on the HOLD-th tick
        supply_ok = 1'b1;
        ticks(HOLD - 1);
        expect_on("R6 before last tick", 1'b1);
        tick_once();
        expect_on("R6 released", 1'b0);

        // R3: supply drop reasserts and ticks are ignored while low
        supply_ok = 1'b0;
        expect_on("R3 drop", 1'b1);
        ticks(HOLD + 2);
        expect_on("R3 held while low", 1'b1);

        // R7: one-cycle dip mid hold-off restarts the count
        supply_ok = 1'b1;
        ticks(5);
        supply_ok = 1'b0;
        step(1);
        supply_ok = 1'b1;
        ticks(HOLD - 1);
        expect_on("R7 restart not done", 1'b1);
        tick_once();
        expect_on("R7 restart released", 1'b0);

        // R5: pulse one cycle too short is dropped
        man_rst_n = 1'b0;
        step(MINP - 1);
        man_rst_n = 1'b1;
        step(8);
        expect_on("R5 short pulse", 1'b0);

        // R4: exact recognition latency (2 + MINP + 1 edges)
        man_rst_n = 1'b0;
        step(2 + MINP - 1);
        expect_on("R4 edge before", 1'b0);
        expect_on("R4 asserted", 1'b1);
        ticks(HOLD + 2);
        expect_on("R4 held while low", 1'b1);

        // R8: hold-off after manual release
        man_rst_n = 1'b1;
        step(4);
        ticks(HOLD - 1);
        expect_on("R8 not done", 1'b1);
        tick_once();
        expect_on("R8 released", 1'b0);

        // R7: manual request during hold-off restarts the count
        supply_ok = 1'b0;
        step(1);
        supply_ok = 1'b1;
        ticks(4);
        man_rst_n = 1'b0;
        step(5);
        man_rst_n = 1'b1;
        step(4);
        ticks(HOLD - 1);
        expect_on("R7 manual restart not done", 1'b1);
        tick_once();
        expect_on("R7 manual restart released", 1'b0);

        step(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5ns);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run ended=0 expected 1");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule